// File: doc/BRIEF.md
# Byte Copy Engine with Register Control

The block moves a run of bytes from one place in memory to another under software control. Software sets up three values through a small bank of 32-bit registers: where to read, where to write and how many bytes to move. It then writes a command word. The engine walks the run one byte at a time over a simple byte-wide memory port. For each byte it issues a read, waits for the returned data and writes that byte at the matching destination offset. Addresses rise by one after each byte.

Register accesses are not handshaked. Each access starts on the rising edge of a decoded read strobe or a decoded write strobe, and the strobes are sampled in the system clock domain. Software polls a status word until the busy bit clears. A sticky flag in the same word records an access that hit a wrong offset, or a command that arrived while a copy was still running. A second command code clears the engine's setup and the flag.

Top module: `bcp_top`

## Requirements
- R1: Synchronous active-low reset leaves the read-data port at zero, both memory enables low and the status word at zero.
- R2: Write offsets are 0x00 command, 0x01 status, 0x02 source address, 0x03 destination address and 0x04 byte count. Writing offsets 0x02 to 0x04 stores the data word.
- R3: On a rising edge of the read strobe at offset 0x01, the read-data port takes the status word on the next clock. The word holds busy in bit 0, the invalid flag in bit 1 and zero in every other bit.
- R4: Command value 0x00000001 copies count bytes. Byte i is read from source+i and written to destination+i, in ascending order of i, each read finishing before its write. No other memory location changes.
- R5: The busy bit reads 1 from the clock after an accepted copy command until the last byte has been written, and then reads 0.
- R6: A copy command with a count of zero makes no memory access and leaves busy at 0.
- R7: A read at any offset other than 0x01, or a write at any offset above 0x04, sets the invalid flag.
- R8: The invalid flag stays set until a reset command clears it, or until a status write loads it from data bit 1.
- R9: Command value 0x00000002 clears the source, destination and count registers and the invalid flag.
- R10: A command value other than 0x1 or 0x2 has no effect on registers, status or memory.
- R11: Any command written while busy is ignored, the running copy completes unchanged, and the invalid flag is set.
- R12: An access happens once per rising strobe edge, however long the strobe is held high.
- R13: For each byte the engine asserts the read enable for one cycle and waits for read-data-valid. It then asserts the write enable for one cycle. The two enables are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_off | input | 8 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, updated on a read edge |
| reg_rd | input | 1 | Decoded read strobe, acts on its rising edge |
| reg_wr | input | 1 | Decoded write strobe, acts on its rising edge |
| mem_addr | output | ADDR_W | Byte address for the memory port |
| mem_rd_en | output | 1 | One-cycle read request |
| mem_wr_en | output | 1 | One-cycle write request |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte returned by a read |
| mem_rvalid | input | 1 | Qualifies mem_rdata |

## Verification
A sequencer that skips or repeats a state has visible effects. It changes the number of enable pulses for each copy, and it leaves a wrong byte or a shifted byte in the destination run, so it shows up as soon as the run is compared against a reference copy. A stuck busy bit makes the status poll time out within a few hundred cycles. A dropped busy bit lets a second command through, and the invalid flag then reads 0 where it should read 1. Bad edge detection shows up as repeated copies or a spurious invalid flag while a strobe is held high. A status read is enough to expose this, and it comes back one clock after the strobe edge.

// File: rtl/bcp_pkg.sv
// Shared constants and types for the byte copy engine.
// Assumes register offsets fit in 8 bits and command words in 32 bits.
package bcp_pkg;
    localparam logic [7:0]  OFF_CMD    = 8'h00;
    localparam logic [7:0]  OFF_STATUS = 8'h01;
    localparam logic [7:0]  OFF_SRC    = 8'h02;
    localparam logic [7:0]  OFF_DST    = 8'h03;
    localparam logic [7:0]  OFF_CNT    = 8'h04;

    localparam logic [31:0] CMD_COPY   = 32'h0000_0001;
    localparam logic [31:0] CMD_CLEAR  = 32'h0000_0002;

    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_BAD_BIT  = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RREQ,
        ST_RWAIT,
        ST_WRITE,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/bcp_edge.sv
// Rising-edge detector for N level strobes in the clk domain.
// Assumes strobes are already synchronous to clk; each output pulses for
// one cycle in the cycle when its strobe is first seen high.
module bcp_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    for (genvar gi = 0; gi < N; gi++) begin : g_det
        logic last_q;

        // Remember each strobe's level from the previous clock.
        always_ff @(posedge clk) begin
            if (!rst_n) last_q <= 1'b0;
            else        last_q <= lvl[gi];
        end

        assign rise[gi] = lvl[gi] & ~last_q;

        assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
            rise[gi] |=> !rise[gi]);
    end
endmodule

// File: rtl/bcp_regs.sv
// Register bank and command decode for the byte copy engine.
// Acts on one-cycle read/write pulses from the edge detector; issues a
// one-cycle start pulse for an accepted copy with a non-zero count.
// Assumes ADDR_W and CNT_W are at most 32.
module bcp_regs
    import bcp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        off,
    input  logic [31:0]       wdata,
    input  logic              rd_pulse,
    input  logic              wr_pulse,
    input  logic              seq_busy,
    output logic [31:0]       rdata,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [CNT_W-1:0]  byte_cnt,
    output logic              start
);
    logic bad_q;
    logic busy_eff;

    // A pending start counts as busy so no command slips in behind it.
    assign busy_eff = seq_busy | start;

    // Register writes, command decode, status reads and invalid-flag tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_addr <= '0;
            dst_addr <= '0;
            byte_cnt <= '0;
            bad_q    <= 1'b0;
            start    <= 1'b0;
            rdata    <= '0;
        end else begin
            start <= 1'b0;
            if (wr_pulse) begin
                case (off)
                    OFF_CMD: begin
                        if (busy_eff) begin
                            bad_q <= 1'b1;
                        end else if (wdata == CMD_COPY) begin
                            start <= (byte_cnt != '0);
                        end else if (wdata == CMD_CLEAR) begin
                            src_addr <= '0;
                            dst_addr <= '0;
                            byte_cnt <= '0;
                            bad_q    <= 1'b0;
                        end
                    end
                    OFF_STATUS: bad_q    <= wdata[STAT_BAD_BIT];
                    OFF_SRC:    src_addr <= wdata[ADDR_W-1:0];
                    OFF_DST:    dst_addr <= wdata[ADDR_W-1:0];
                    OFF_CNT:    byte_cnt <= wdata[CNT_W-1:0];
                    default:    bad_q    <= 1'b1;
                endcase
            end
            if (rd_pulse) begin
                if (off == OFF_STATUS) begin
                    rdata                <= '0;
                    rdata[STAT_BUSY_BIT] <= busy_eff;
                    rdata[STAT_BAD_BIT]  <= bad_q;
                end else begin
                    bad_q <= 1'b1;
                end
            end
        end
    end

    // R11: a command arriving while busy must raise the invalid flag.
    assert_busy_cmd_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && off == OFF_CMD && busy_eff) |=> bad_q);

    // R9: an accepted clear command empties the setup and the flag.
    assert_clear_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && !rd_pulse && off == OFF_CMD && wdata == CMD_CLEAR && !busy_eff)
        |=> (byte_cnt == '0 && src_addr == '0 && dst_addr == '0 && !bad_q));

    // R6: a zero-count copy never produces a start pulse.
    assert_zero_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && off == OFF_CMD && wdata == CMD_COPY && byte_cnt == '0) |=> !start);

    // R7: a read of a non-status offset raises the invalid flag.
    assert_bad_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pulse && off != OFF_STATUS) |=> bad_q);
endmodule

// File: rtl/bcp_seq.sv
// Copy sequencer: moves one byte per iteration over a byte-wide memory
// port with incrementing addresses. Assumes start is only pulsed while
// idle and only with a non-zero count; read data may take any number of
// cycles to return, qualified by rvalid.
module bcp_seq
    import bcp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_in,
    input  logic [ADDR_W-1:0] dst_in,
    input  logic [CNT_W-1:0]  cnt_in,
    output logic              busy,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_rvalid
);
    seq_state_t        state;
    logic [ADDR_W-1:0] src_c;
    logic [ADDR_W-1:0] dst_c;
    logic [CNT_W-1:0]  left;
    logic [7:0]        byte_q;

    // State machine plus the running addresses, count and byte holder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            src_c  <= '0;
            dst_c  <= '0;
            left   <= '0;
            byte_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start && cnt_in != '0) begin
                        src_c <= src_in;
                        dst_c <= dst_in;
                        left  <= cnt_in;
                        state <= ST_RREQ;
                    end
                end
                ST_RREQ:  state <= ST_RWAIT;
                ST_RWAIT: begin
                    if (mem_rvalid) begin
                        byte_q <= mem_rdata;
                        state  <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    src_c <= src_c + 1'b1;
                    dst_c <= dst_c + 1'b1;
                    left  <= left - 1'b1;
                    state <= (left == CNT_W'(1)) ? ST_DONE : ST_RREQ;
                end
                ST_DONE:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Memory port drive decoded from the state.
    always_comb begin
        mem_rd_en = (state == ST_RREQ);
        mem_wr_en = (state == ST_WRITE);
        mem_addr  = (state == ST_WRITE) ? dst_c : src_c;
        mem_wdata = byte_q;
        busy      = (state != ST_IDLE);
    end

    // R13: every write is preceded by returned read data.
    assert_write_after_data_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($past(state) == ST_RWAIT && $past(mem_rvalid)));

    // R4: the next read after a write is one byte further on.
    assert_src_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_wr_en)) |-> (src_c == ADDR_W'($past(src_c) + 1'b1)));

    // R11: the register bank never starts a copy over a running one.
    assert_start_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (state == ST_IDLE));

    // R13: at most one enable is high in any cycle.
    assert_one_enable_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_en, mem_wr_en}));
endmodule

// File: rtl/bcp_top.sv
// Top of the register-programmed byte copy engine: edge detection on the
// decoded strobes, register bank, and copy sequencer. Assumes strobes,
// offset and data are synchronous to clk and held stable around an edge.
module bcp_top
    import bcp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        reg_off,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              reg_rd,
    input  logic              reg_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_rvalid
);
    localparam int NSTB = 2;

    logic [NSTB-1:0]   stb_rise;
    logic [ADDR_W-1:0] src_addr;
    logic [ADDR_W-1:0] dst_addr;
    logic [CNT_W-1:0]  byte_cnt;
    logic              start;
    logic              seq_busy;

    bcp_edge #(.N(NSTB)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({reg_wr, reg_rd}),
        .rise  (stb_rise)
    );

    bcp_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .off      (reg_off),
        .wdata    (reg_wdata),
        .rd_pulse (stb_rise[0]),
        .wr_pulse (stb_rise[1]),
        .seq_busy (seq_busy),
        .rdata    (reg_rdata),
        .src_addr (src_addr),
        .dst_addr (dst_addr),
        .byte_cnt (byte_cnt),
        .start    (start)
    );

    bcp_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .src_in     (src_addr),
        .dst_in     (dst_addr),
        .cnt_in     (byte_cnt),
        .busy       (seq_busy),
        .mem_addr   (mem_addr),
        .mem_rd_en  (mem_rd_en),
        .mem_wr_en  (mem_wr_en),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_rvalid (mem_rvalid)
    );
endmodule

// File: tb/sim_bcp_top.sv
module sim_bcp_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_off = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd_en, mem_wr_en;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_rvalid = 1'b0;

    logic [7:0]  mem [256];
    logic [7:0]  ref_mem [256];
    int          wr_count = 0;
    int          rd_count = 0;
    int          checks = 0;
    int          errors = 0;

    // Copy vectors: {source, destination, count}
    localparam logic [23:0] VEC [5] = '{
        24'h0A_64_08, 24'h00_C8_01, 24'h32_3C_14, 24'h78_6E_0F, 24'h1E_96_28
    };

    always #10 clk = ~clk;

    bcp_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_off(reg_off), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
    );

    // Byte memory model: one-cycle read latency, pattern fill under reset.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 37 + 11);
            mem_rvalid <= 1'b0;
        end else begin
            mem_rvalid <= mem_rd_en;
            if (mem_rd_en) begin
                mem_rdata <= mem[mem_addr[7:0]];
                rd_count  <= rd_count + 1;
            end
            if (mem_wr_en) begin
                mem[mem_addr[7:0]] <= mem_wdata;
                wr_count <= wr_count + 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ref_init();
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'(i * 37 + 11);
    endtask

    task automatic ref_copy(input int s, input int d, input int n);
        for (int i = 0; i < n; i++) ref_mem[(d + i) & 255] = ref_mem[(s + i) & 255];
    endtask

    task automatic reg_write(input logic [7:0] off, input logic [31:0] data);
        @(negedge clk); reg_off = off; reg_wdata = data; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic reg_read(input logic [7:0] off, output logic [31:0] data);
        @(negedge clk); reg_off = off; reg_rd = 1'b1;
        @(negedge clk); data = reg_rdata; reg_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_idle(output logic [31:0] st);
        for (int k = 0; k < 400; k++) begin
            reg_read(8'h01, st);
            if (st[0] == 1'b0) break;
        end
    endtask

    task automatic cmp_mem(input string tag);
        int bad = -1;
        for (int i = 0; i < 256; i++)
            if (bad < 0 && mem[i] !== ref_mem[i]) bad = i;
        if (bad < 0) check(1'b1, tag, 0, 0);
        else check(1'b0, $sformatf("%s byte@%0d", tag, bad), mem[bad], ref_mem[bad]);
    endtask

    task automatic setup(input int s, input int d, input int n);
        reg_write(8'h02, 32'(s));
        reg_write(8'h03, 32'(d));
        reg_write(8'h04, 32'(n));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] st;
        int w0, r0;
        ref_init();
        repeat (5) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check(reg_rdata == 0, "R1 rdata after reset", reg_rdata, 0);
        check(!mem_rd_en && !mem_wr_en, "R1 enables after reset", {mem_rd_en, mem_wr_en}, 0);
        reg_read(8'h01, st);
        check(st == 0, "R1 R3 status after reset", st, 0);

        // R2 R4 R5 R13: vector table walk
        foreach (VEC[v]) begin
            int s = int'(VEC[v][23:16]);
            int d = int'(VEC[v][15:8]);
            int n = int'(VEC[v][7:0]);
            setup(s, d, n);
            w0 = wr_count; r0 = rd_count;
            reg_write(8'h00, 32'h1);
            reg_read(8'h01, st);
            check(st == 32'h1, "R5 busy after copy command", st, 1);
            wait_idle(st);
            check(st == 0, "R5 idle after copy", st, 0);
            check(wr_count - w0 == n && rd_count - r0 == n, "R13 R2 access count",
                  wr_count - w0, n);
            ref_copy(s, d, n);
            cmp_mem("R4 copied run");
        end

        // R6: zero count
        setup(5, 7, 0);
        w0 = wr_count; r0 = rd_count;
        reg_write(8'h00, 32'h1);
        reg_read(8'h01, st);
        check(st == 0, "R6 zero count not busy", st, 0);
        check(wr_count == w0 && rd_count == r0, "R6 zero count no access", wr_count - w0, 0);

        // R7 R8: invalid flag set and held
        reg_read(8'h00, st);
        reg_read(8'h01, st);
        check(st == 32'h2, "R7 read of command offset flags", st, 2);
        reg_read(8'h01, st);
        check(st == 32'h2, "R8 flag sticky", st, 2);
        reg_write(8'h01, 32'h0);
        reg_read(8'h01, st);
        check(st == 0, "R8 status write clears flag", st, 0);
        reg_write(8'h09, 32'h1234);
        reg_read(8'h01, st);
        check(st == 32'h2, "R7 write of unmapped offset flags", st, 2);

        // R9: clear command empties setup and flag
        setup(3, 240, 6);
        reg_write(8'h00, 32'h2);
        reg_read(8'h01, st);
        check(st == 0, "R9 clear command status", st, 0);
        w0 = wr_count;
        reg_write(8'h00, 32'h1);
        repeat (10) @(negedge clk);
        check(wr_count == w0, "R9 count cleared so copy moves nothing", wr_count - w0, 0);
        cmp_mem("R9 memory unchanged");

        // R10: unknown command value
        setup(5, 210, 4);
        w0 = wr_count;
        reg_write(8'h00, 32'h7);
        repeat (10) @(negedge clk);
        reg_read(8'h01, st);
        check(st == 0 && wr_count == w0, "R10 unknown command no effect", st, 0);
        reg_write(8'h00, 32'h1);
        wait_idle(st);
        check(wr_count - w0 == 4, "R10 setup retained", wr_count - w0, 4);
        ref_copy(5, 210, 4);
        cmp_mem("R10 copy after unknown command");

        // R11: command while busy
        setup(0, 100, 30);
        w0 = wr_count;
        reg_write(8'h00, 32'h1);
        reg_write(8'h00, 32'h2);
        reg_read(8'h01, st);
        check(st == 32'h3, "R11 busy and flagged", st, 3);
        wait_idle(st);
        check(st == 32'h2, "R11 flag remains after copy", st, 2);
        check(wr_count - w0 == 30, "R11 copy completed", wr_count - w0, 30);
        ref_copy(0, 100, 30);
        cmp_mem("R11 copy intact");
        reg_write(8'h01, 32'h0);

        // R12: write strobe held high across the whole copy
        setup(40, 180, 10);
        w0 = wr_count;
        @(negedge clk); reg_off = 8'h00; reg_wdata = 32'h1; reg_wr = 1'b1;
        repeat (80) @(negedge clk);
        reg_wr = 1'b0;
        @(negedge clk);
        reg_read(8'h01, st);
        check(st == 0, "R12 held strobe acts once, no flag", st, 0);
        check(wr_count - w0 == 10, "R12 single copy", wr_count - w0, 10);
        ref_copy(40, 180, 10);
        cmp_mem("R12 copy");

        // R1: reset in the middle of a copy
        setup(0, 128, 60);
        reg_write(8'h00, 32'h1);
        repeat (7) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mem_rd_en && !mem_wr_en && reg_rdata == 0, "R1 reset mid-copy",
              {mem_rd_en, mem_wr_en}, 0);
        reg_read(8'h01, st);
        check(st == 0, "R1 status after mid-copy reset", st, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule